// File: doc/BRIEF.md
# Processor-Side Miss Sequencer for a Snooping Cache

This block sits between a processor and a small cache whose lines each carry a virtual tag, a real tag, a data word, an owner bit and a shared bit. It serves loads and stores. A hit is answered from the array. A store to a line that other caches may hold is turned into a bus write-single request. A miss runs a fixed routine. The routine waits out any earlier flush, then translates the page, either from a line already in the array or by asking the bus for a mapping. Next it freezes a victim line chosen by a round-robin pointer. It posts a flush of that victim when the victim is owned, and issues a block-read for the missing address.

Completion is signalled by the bus side through two clear strobes, one for each transaction-in-progress flag. A flush is posted without waiting for its reply. Only the next miss waits for that flag, so the victim write-back overlaps the fill. The snooper address register is loaded, with its stale and shared flags cleared, whenever a request is about to go out for a real address.

Top module: `csq_top`

## Requirements
- R1: While reset is held, `nonfb_tip`, `fb_tip`, `p_ready`, `rq_valid`, `fb_valid` and `snp_load` are all 0. After reset, every line is invalid and the victim pointer is at line 0.
- R2: A fetch whose address equals a valid line's virtual tag completes with that line's word on `p_rdata`. It issues no bus request and does not wait for a pending flush.
- R3: A store hit on a line whose shared bit is 0 writes the word into the line and sets its owner bit. It issues no bus request.
- R4: A store hit on a shared line first pulses `snp_load` with the line's real address. It then issues a request with `rq_cmd`=1 (write-single), carrying the real address and the store word. It completes only after `nonfb_tip` clears. The line then holds the word, its owner bit is set and its shared bit takes `rply_shared`.
- R5: On a miss, no bus request is issued while `fb_tip` is 1 from an earlier flush.
- R6: The virtual page is address bits [AW-1:AW-PW] and the offset is the remaining low bits. If a valid line's virtual page equals the miss page, the real page of the lowest-numbered such line is used. Otherwise a request with `rq_cmd`=2 (map) carries the virtual address, and the real page is taken from `rply_page` when `nonfb_tip` clears. The miss real address is the real page joined to the virtual offset.
- R7: After translation, `snp_load` pulses with the miss real address before the block-read is issued.
- R8: If the frozen victim is valid and owned, `fb_valid` pulses with the victim's real tag and data, and `fb_tip` is set. The block-read follows without waiting for `clr_fb`.
- R9: The block-read is a request with `rq_cmd`=0, the miss real address on `rq_addr` and the victim's real tag on `rq_data`. It sets `nonfb_tip`. When the flag clears, the victim line is filled with `rply_data`, owner 0 and shared from `rply_shared`. A fetch then returns the fill word.
- R10: A store miss fills the line as in R9 and then repeats the store from the tag lookup, so it finishes as a store hit.
- R11: The victim is the line under a round-robin pointer. The pointer advances by one, wrapping at NL, only when a fill is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| p_req | input | 1 | Processor access strobe, taken when idle |
| p_we | input | 1 | 1 for store, 0 for fetch |
| p_va | input | AW | Virtual word address |
| p_wdata | input | DW | Store word |
| p_ready | output | 1 | One-cycle completion pulse |
| p_rdata | output | DW | Fetched word, valid with `p_ready` |
| rq_valid | output | 1 | Request buffer issue pulse |
| rq_cmd | output | 2 | 0 block-read, 1 write-single, 2 map |
| rq_addr | output | AW | Real address (virtual address for map) |
| rq_data | output | DW | Store word or victim real tag |
| fb_valid | output | 1 | Flush post pulse |
| fb_addr | output | AW | Victim real tag |
| fb_data | output | DW | Victim data |
| snp_load | output | 1 | Snooper address load and flag clear |
| snp_addr | output | AW | Address for the snooper |
| clr_nonfb | input | 1 | Bus side ends the non-flush transaction |
| clr_fb | input | 1 | Bus side ends the flush |
| rply_page | input | PW | Real page from a map reply |
| rply_data | input | DW | Fill word |
| rply_shared | input | 1 | Shared indication of the reply |
| nonfb_tip | output | 1 | Non-flush transaction in progress |
| fb_tip | output | 1 | Flush in progress |

## Verification
Assertions check the following on every cycle:
- a request always raises the non-flush flag, and no request goes out while that flag was already set;
- a flush appears only for an owned, valid victim, and it raises the flush flag;
- translation never starts while a flush is pending;
- the flush flag holds until it is cleared;
- the victim pointer moves only on a fill;
- local updates touch only valid lines.

Only the bench scenarios can show the data path. They show that a flushed word reaches memory and returns on a later miss. They show that victims follow the round-robin order, that a page match avoids a map request, and that a store miss ends as a local store or a write-single, depending on the shared reply.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [1:0] {
    CMD_RB  = 2'd0,
    CMD_WS  = 2'd1,
    CMD_MAP = 2'd2
  } bus_cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_LOOK, S_WSWAIT, S_FBWAIT, S_XLATE, S_MAPWAIT,
    S_FREEZE, S_VTAG, S_VDATA, S_RB, S_RBWAIT
  } seq_state_e;
endpackage

// File: rtl/csq_array.sv
module csq_array #(
  parameter int NL = 4,
  parameter int AW = 6,
  parameter int PW = 4,
  parameter int DW = 16,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] look_va,
  output logic          hit,
  output logic [IW-1:0] hit_idx,
  output logic [DW-1:0] hit_data,
  output logic          hit_shr,
  output logic [AW-1:0] hit_ra,
  output logic          pg_hit,
  output logic [PW-1:0] pg_rpage,
  input  logic [IW-1:0] vic_idx,
  output logic          vic_valid,
  output logic          vic_own,
  output logic [AW-1:0] vic_ra,
  output logic [DW-1:0] vic_data,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic [DW-1:0] upd_data,
  input  logic          upd_shr,
  input  logic          fill_en,
  input  logic [IW-1:0] fill_idx,
  input  logic [AW-1:0] fill_va,
  input  logic [AW-1:0] fill_ra,
  input  logic [DW-1:0] fill_data,
  input  logic          fill_shr
);
  function automatic logic [PW-1:0] page_of(input logic [AW-1:0] a);
    return a[AW-1:AW-PW];
  endfunction

  logic [NL-1:0]         lv, lown, lshr;
  logic [NL-1:0][AW-1:0] lvt, lrt;
  logic [NL-1:0][DW-1:0] ldat;
  logic [IW-1:0]         pg_idx;

  for (genvar g = 0; g < NL; g++) begin : g_line
    logic          v, own, shr;
    logic [AW-1:0] vt, rt;
    logic [DW-1:0] dat;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v <= 1'b0; own <= 1'b0; shr <= 1'b0;
        vt <= '0; rt <= '0; dat <= '0;
      end else if (fill_en && fill_idx == IW'(g)) begin
        v <= 1'b1; own <= 1'b0; shr <= fill_shr;
        vt <= fill_va; rt <= fill_ra; dat <= fill_data;
      end else if (upd_en && upd_idx == IW'(g)) begin
        own <= 1'b1; shr <= upd_shr; dat <= upd_data;
      end
    end
    assign lv[g]   = v;
    assign lown[g] = own;
    assign lshr[g] = shr;
    assign lvt[g]  = vt;
    assign lrt[g]  = rt;
    assign ldat[g] = dat;
  end

  always_comb begin
    hit = 1'b0; hit_idx = '0; pg_hit = 1'b0; pg_idx = '0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (lv[i] && lvt[i] == look_va) begin
        hit = 1'b1; hit_idx = IW'(i);
      end
      if (lv[i] && page_of(lvt[i]) == page_of(look_va)) begin
        pg_hit = 1'b1; pg_idx = IW'(i);
      end
    end
  end

  assign hit_data  = ldat[hit_idx];
  assign hit_shr   = lshr[hit_idx];
  assign hit_ra    = lrt[hit_idx];
  assign pg_rpage  = page_of(lrt[pg_idx]);
  assign vic_valid = lv[vic_idx];
  assign vic_own   = lown[vic_idx];
  assign vic_ra    = lrt[vic_idx];
  assign vic_data  = ldat[vic_idx];

  // R3: a local update may only land on a line that holds valid tags
  p_upd_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> lv[upd_idx]);
  // R9: a filled line reads back valid with its owner bit clear
  p_fill_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (lv[$past(fill_idx)] && !lown[$past(fill_idx)]));
endmodule

// File: rtl/csq_flags.sv
module csq_flags #(
  parameter int PW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_nonfb,
  input  logic          set_fb,
  input  logic          clr_nonfb,
  input  logic          clr_fb,
  input  logic [PW-1:0] rply_page,
  input  logic [DW-1:0] rply_data,
  input  logic          rply_shared,
  output logic          nonfb_tip,
  output logic          fb_tip,
  output logic [PW-1:0] rp_q,
  output logic [DW-1:0] rd_q,
  output logic          rs_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nonfb_tip <= 1'b0; fb_tip <= 1'b0;
      rp_q <= '0; rd_q <= '0; rs_q <= 1'b0;
    end else begin
      if (set_nonfb)      nonfb_tip <= 1'b1;
      else if (clr_nonfb) nonfb_tip <= 1'b0;
      if (set_fb)         fb_tip <= 1'b1;
      else if (clr_fb)    fb_tip <= 1'b0;
      if (clr_nonfb) begin
        rp_q <= rply_page; rd_q <= rply_data; rs_q <= rply_shared;
      end
    end
  end

  // R5: a posted flush stays pending until the bus side ends it
  p_fb_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_tip && !clr_fb) |=> fb_tip);
  // R9: raising the non-flush flag takes effect on the next cycle
  p_nonfb_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_nonfb |=> nonfb_tip);
endmodule

// File: rtl/csq_victim.sv
module csq_victim #(
  parameter int NL = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [IW-1:0] ptr
);
  function automatic logic [IW-1:0] next_ptr(input logic [IW-1:0] p);
    return (p == IW'(NL - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= next_ptr(ptr);
  end

  // R11: the pointer only moves when a fill is written
  p_rr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr));
endmodule

// File: rtl/csq_top.sv
module csq_top
  import csq_pkg::*;
#(
  parameter int NL = 4,
  parameter int AW = 6,
  parameter int PW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          p_req,
  input  logic          p_we,
  input  logic [AW-1:0] p_va,
  input  logic [DW-1:0] p_wdata,
  output logic          p_ready,
  output logic [DW-1:0] p_rdata,
  output logic          rq_valid,
  output logic [1:0]    rq_cmd,
  output logic [AW-1:0] rq_addr,
  output logic [DW-1:0] rq_data,
  output logic          fb_valid,
  output logic [AW-1:0] fb_addr,
  output logic [DW-1:0] fb_data,
  output logic          snp_load,
  output logic [AW-1:0] snp_addr,
  input  logic          clr_nonfb,
  input  logic          clr_fb,
  input  logic [PW-1:0] rply_page,
  input  logic [DW-1:0] rply_data,
  input  logic          rply_shared,
  output logic          nonfb_tip,
  output logic          fb_tip
);
  localparam int IW = (NL > 1) ? $clog2(NL) : 1;
  localparam int OW = AW - PW;

  function automatic logic [AW-1:0] join_ra(input logic [PW-1:0] pg, input logic [AW-1:0] va);
    return {pg, va[OW-1:0]};
  endfunction

  seq_state_e st, st_n;
  logic          we_q;
  logic [AW-1:0] va_q, ra_q, vrt_q, ra_n;
  logic [DW-1:0] wd_q;
  logic [IW-1:0] hidx_q, vic_q, rr_ptr;

  logic          a_hit, a_hit_shr, a_pg_hit, a_vic_valid, a_vic_own;
  logic [IW-1:0] a_hit_idx;
  logic [DW-1:0] a_hit_data, a_vic_data;
  logic [AW-1:0] a_hit_ra, a_vic_ra;
  logic [PW-1:0] a_pg_rpage;

  logic [PW-1:0] rp_q;
  logic [DW-1:0] rd_q;
  logic          rs_q;

  logic          ready_n, rqv_n, fbv_n, snp_n;
  logic [DW-1:0] rdata_n, rqd_n;
  bus_cmd_e      rqc_n;
  logic [AW-1:0] rqa_n, snpa_n;
  logic          set_nonfb, set_fb, ld_ra, ld_hidx, ld_vic, ld_vrt;
  logic          upd_en, upd_shr, fill_en;
  logic [IW-1:0] upd_idx;
  logic [DW-1:0] upd_data;

  csq_array #(.NL(NL), .AW(AW), .PW(PW), .DW(DW), .IW(IW)) u_array (
    .clk(clk), .rst_n(rst_n), .look_va(va_q),
    .hit(a_hit), .hit_idx(a_hit_idx), .hit_data(a_hit_data), .hit_shr(a_hit_shr), .hit_ra(a_hit_ra),
    .pg_hit(a_pg_hit), .pg_rpage(a_pg_rpage),
    .vic_idx(vic_q), .vic_valid(a_vic_valid), .vic_own(a_vic_own), .vic_ra(a_vic_ra), .vic_data(a_vic_data),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_data(upd_data), .upd_shr(upd_shr),
    .fill_en(fill_en), .fill_idx(vic_q), .fill_va(va_q), .fill_ra(ra_q), .fill_data(rd_q), .fill_shr(rs_q)
  );

  csq_flags #(.PW(PW), .DW(DW)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_nonfb(set_nonfb), .set_fb(set_fb),
    .clr_nonfb(clr_nonfb), .clr_fb(clr_fb), .rply_page(rply_page), .rply_data(rply_data),
    .rply_shared(rply_shared), .nonfb_tip(nonfb_tip), .fb_tip(fb_tip),
    .rp_q(rp_q), .rd_q(rd_q), .rs_q(rs_q)
  );

  csq_victim #(.NL(NL), .IW(IW)) u_victim (
    .clk(clk), .rst_n(rst_n), .adv(fill_en), .ptr(rr_ptr)
  );

  always_comb begin
    st_n = st;
    ready_n = 1'b0; rdata_n = '0;
    rqv_n = 1'b0; rqc_n = CMD_RB; rqa_n = '0; rqd_n = '0;
    fbv_n = 1'b0; snp_n = 1'b0; snpa_n = '0;
    set_nonfb = 1'b0; set_fb = 1'b0;
    ld_ra = 1'b0; ra_n = '0; ld_hidx = 1'b0; ld_vic = 1'b0; ld_vrt = 1'b0;
    upd_en = 1'b0; upd_idx = '0; upd_data = '0; upd_shr = 1'b0;
    fill_en = 1'b0;
    unique case (st)
      S_IDLE: if (p_req) st_n = S_LOOK;
      S_LOOK: begin
        if (!a_hit) begin
          st_n = S_FBWAIT;
        end else if (!we_q) begin
          ready_n = 1'b1; rdata_n = a_hit_data; st_n = S_IDLE;
        end else if (!a_hit_shr) begin
          upd_en = 1'b1; upd_idx = a_hit_idx; upd_data = wd_q; upd_shr = 1'b0;
          ready_n = 1'b1; st_n = S_IDLE;
        end else begin
          snp_n = 1'b1; snpa_n = a_hit_ra;
          rqv_n = 1'b1; rqc_n = CMD_WS; rqa_n = a_hit_ra; rqd_n = wd_q;
          set_nonfb = 1'b1; ld_hidx = 1'b1; st_n = S_WSWAIT;
        end
      end
      S_WSWAIT: if (!nonfb_tip) begin
        upd_en = 1'b1; upd_idx = hidx_q; upd_data = wd_q; upd_shr = rs_q;
        ready_n = 1'b1; st_n = S_IDLE;
      end
      S_FBWAIT: if (!fb_tip) st_n = S_XLATE;
      S_XLATE: begin
        if (a_pg_hit) begin
          ld_ra = 1'b1; ra_n = join_ra(a_pg_rpage, va_q); st_n = S_FREEZE;
        end else begin
          rqv_n = 1'b1; rqc_n = CMD_MAP; rqa_n = va_q;
          set_nonfb = 1'b1; st_n = S_MAPWAIT;
        end
      end
      S_MAPWAIT: if (!nonfb_tip) begin
        ld_ra = 1'b1; ra_n = join_ra(rp_q, va_q); st_n = S_FREEZE;
      end
      S_FREEZE: begin
        snp_n = 1'b1; snpa_n = ra_q; ld_vic = 1'b1; st_n = S_VTAG;
      end
      S_VTAG: begin
        ld_vrt = 1'b1; st_n = S_VDATA;
      end
      S_VDATA: begin
        if (a_vic_valid && a_vic_own) begin
          fbv_n = 1'b1; set_fb = 1'b1;
        end
        st_n = S_RB;
      end
      S_RB: begin
        rqv_n = 1'b1; rqc_n = CMD_RB; rqa_n = ra_q; rqd_n = DW'(vrt_q);
        set_nonfb = 1'b1; st_n = S_RBWAIT;
      end
      S_RBWAIT: if (!nonfb_tip) begin
        fill_en = 1'b1;
        if (we_q) begin
          st_n = S_LOOK;
        end else begin
          ready_n = 1'b1; rdata_n = rd_q; st_n = S_IDLE;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; we_q <= 1'b0; va_q <= '0; wd_q <= '0;
      ra_q <= '0; vrt_q <= '0; hidx_q <= '0; vic_q <= '0;
      p_ready <= 1'b0; p_rdata <= '0;
      rq_valid <= 1'b0; rq_cmd <= 2'd0; rq_addr <= '0; rq_data <= '0;
      fb_valid <= 1'b0; fb_addr <= '0; fb_data <= '0;
      snp_load <= 1'b0; snp_addr <= '0;
    end else begin
      st <= st_n;
      if (st == S_IDLE && p_req) begin
        we_q <= p_we; va_q <= p_va; wd_q <= p_wdata;
      end
      if (ld_ra)   ra_q <= ra_n;
      if (ld_hidx) hidx_q <= a_hit_idx;
      if (ld_vic)  vic_q <= rr_ptr;
      if (ld_vrt)  vrt_q <= a_vic_ra;
      p_ready <= ready_n;
      if (ready_n) p_rdata <= rdata_n;
      rq_valid <= rqv_n;
      if (rqv_n) begin
        rq_cmd <= rqc_n; rq_addr <= rqa_n; rq_data <= rqd_n;
      end
      fb_valid <= fbv_n;
      if (fbv_n) begin
        fb_addr <= vrt_q; fb_data <= a_vic_data;
      end
      snp_load <= snp_n;
      if (snp_n) snp_addr <= snpa_n;
    end
  end

  // R9: every request raises the non-flush flag together with it
  p_rq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |-> nonfb_tip);
  // R9: no request is issued while an earlier one is still in flight
  p_rq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |-> !$past(nonfb_tip));
  // R8: a flush is posted only for a valid, owned victim
  p_fb_owned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |-> $past(a_vic_valid && a_vic_own));
  // R8: a posted flush sets the flush-in-progress flag
  p_fb_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |-> fb_tip);
  // R5: translation never starts with a flush outstanding
  p_xlate_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XLATE) |-> !fb_tip);
  // R2: completion is a single-cycle pulse
  p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    p_ready |=> !p_ready);
endmodule

// File: tb/test_csq_top.sv
module test_csq_top;
  localparam int AW = 6, PW = 4, DW = 16, NL = 4, FB_DLY = 20, NV = 17;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] va;
    logic [DW-1:0] wd;
    logic          shr;
    logic [DW-1:0] exp_rd;
    logic          exp_map;
    logic          exp_fb;
    logic          exp_ws;
    logic [AW-1:0] exp_fba;
    logic [AW-1:0] exp_snp;
  } vec_t;

  // memory model: word at real address a starts as 0x0100+a; map gives real page = virtual page ^ 3
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'h04, 16'h0000, 1'b0, 16'h0108, 1'b1, 1'b0, 1'b0, 6'h00, 6'h08},
    '{1'b0, 6'h05, 16'h0000, 1'b0, 16'h0109, 1'b0, 1'b0, 1'b0, 6'h00, 6'h09},
    '{1'b0, 6'h04, 16'h0000, 1'b0, 16'h0108, 1'b0, 1'b0, 1'b0, 6'h00, 6'h3F},
    '{1'b1, 6'h04, 16'hBEEF, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'h00, 6'h3F},
    '{1'b0, 6'h04, 16'h0000, 1'b0, 16'hBEEF, 1'b0, 1'b0, 1'b0, 6'h00, 6'h3F},
    '{1'b1, 6'h08, 16'h1234, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b1, 6'h00, 6'h04},
    '{1'b0, 6'h08, 16'h0000, 1'b0, 16'h1234, 1'b0, 1'b0, 1'b0, 6'h00, 6'h3F},
    '{1'b1, 6'h08, 16'h5678, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 6'h00, 6'h04},
    '{1'b1, 6'h08, 16'h9ABC, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 6'h00, 6'h3F},
    '{1'b0, 6'h0C, 16'h0000, 1'b0, 16'h0100, 1'b1, 1'b0, 1'b0, 6'h00, 6'h00},
    '{1'b0, 6'h06, 16'h0000, 1'b0, 16'h010A, 1'b0, 1'b1, 1'b0, 6'h08, 6'h0A},
    '{1'b0, 6'h06, 16'h0000, 1'b0, 16'h010A, 1'b0, 1'b0, 1'b0, 6'h00, 6'h3F},
    '{1'b0, 6'h04, 16'h0000, 1'b0, 16'hBEEF, 1'b0, 1'b0, 1'b0, 6'h00, 6'h08},
    '{1'b0, 6'h09, 16'h0000, 1'b0, 16'h0105, 1'b0, 1'b1, 1'b0, 6'h04, 6'h05},
    '{1'b0, 6'h08, 16'h0000, 1'b0, 16'h9ABC, 1'b0, 1'b0, 1'b0, 6'h00, 6'h04},
    '{1'b1, 6'h10, 16'h4444, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 6'h00, 6'h1C},
    '{1'b0, 6'h10, 16'h0000, 1'b0, 16'h4444, 1'b0, 1'b0, 1'b0, 6'h00, 6'h3F}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, p_req = 1'b0, p_we = 1'b0;
  logic [AW-1:0] p_va = '0;
  logic [DW-1:0] p_wdata = '0;
  logic p_ready, rq_valid, fb_valid, snp_load, nonfb_tip, fb_tip;
  logic [DW-1:0] p_rdata, rq_data, fb_data;
  logic [1:0] rq_cmd;
  logic [AW-1:0] rq_addr, fb_addr, snp_addr;
  logic clr_nonfb = 1'b0, clr_fb = 1'b0, rply_shared = 1'b0;
  logic [PW-1:0] rply_page = '0;
  logic [DW-1:0] rply_data = '0;

  csq_top #(.NL(NL), .AW(AW), .PW(PW), .DW(DW)) i_csq_top (
    .clk(clk), .rst_n(rst_n), .p_req(p_req), .p_we(p_we), .p_va(p_va), .p_wdata(p_wdata),
    .p_ready(p_ready), .p_rdata(p_rdata), .rq_valid(rq_valid), .rq_cmd(rq_cmd),
    .rq_addr(rq_addr), .rq_data(rq_data), .fb_valid(fb_valid), .fb_addr(fb_addr),
    .fb_data(fb_data), .snp_load(snp_load), .snp_addr(snp_addr), .clr_nonfb(clr_nonfb),
    .clr_fb(clr_fb), .rply_page(rply_page), .rply_data(rply_data), .rply_shared(rply_shared),
    .nonfb_tip(nonfb_tip), .fb_tip(fb_tip)
  );

  int n_chk = 0, n_fail = 0, fb_cnt = 0, r5_viol = 0, bad_cmd = 0;
  bit finished = 1'b0;
  logic [DW-1:0] mem [64];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(input vec_t v, output logic [DW-1:0] rd, output int nmap,
                        output int nfb, output int nws, output logic [AW-1:0] fba,
                        output logic [AW-1:0] snp, output bit got);
    bit own_fb = 1'b0;
    int rb_cnt = 0;
    logic [DW-1:0] pend_data = '0;
    logic [PW-1:0] pend_page = '0;
    nmap = 0; nfb = 0; nws = 0; fba = '0; snp = '1; got = 1'b0; rd = '0;
    p_req = 1'b1; p_we = v.we; p_va = v.va; p_wdata = v.wd;
    @(negedge clk);
    p_req = 1'b0;
    for (int cyc = 0; cyc < 400 && !got; cyc++) begin
      clr_nonfb = 1'b0; clr_fb = 1'b0;
      if (p_ready) begin got = 1'b1; rd = p_rdata; end
      if (snp_load) snp = snp_addr;
      if (fb_valid) begin
        nfb++; fba = fb_addr; mem[fb_addr] = fb_data; fb_cnt = FB_DLY; own_fb = 1'b1;
      end
      if (rq_valid) begin
        if (fb_tip && !own_fb) r5_viol++;
        case (rq_cmd)
          2'd0: pend_data = mem[rq_addr];
          2'd1: begin nws++; mem[rq_addr] = rq_data; pend_data = '0; end
          2'd2: begin nmap++; pend_page = rq_addr[AW-1:AW-PW] ^ 4'h3; end
          default: bad_cmd++;
        endcase
        rb_cnt = 2;
      end
      if (rb_cnt > 0) begin
        rb_cnt--;
        if (rb_cnt == 0) begin
          clr_nonfb = 1'b1; rply_data = pend_data; rply_page = pend_page; rply_shared = v.shr;
        end
      end
      if (fb_cnt > 0) begin
        fb_cnt--;
        if (fb_cnt == 0) clr_fb = 1'b1;
      end
      if (!got) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    logic [AW-1:0] fba, snp;
    int nmap, nfb, nws;
    bit got;
    for (int i = 0; i < 64; i++) mem[i] = 16'h0100 + DW'(i);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!nonfb_tip && !fb_tip, "R1", "flags in reset", {nonfb_tip, fb_tip}, 0);
    check(!p_ready && !rq_valid && !fb_valid && !snp_load, "R1", "pulses in reset",
          {p_ready, rq_valid, fb_valid, snp_load}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i], rd, nmap, nfb, nws, fba, snp, got);
      check(got, "R2 R9", $sformatf("vec %0d completion", i), got, 1);
      if (!VECS[i].we)
        check(rd == VECS[i].exp_rd, "R2 R9 R10", $sformatf("vec %0d read data", i), rd, VECS[i].exp_rd);
      check(nmap == int'(VECS[i].exp_map), "R6", $sformatf("vec %0d map requests", i), nmap, VECS[i].exp_map);
      check(nfb == int'(VECS[i].exp_fb), "R8 R11", $sformatf("vec %0d flushes", i), nfb, VECS[i].exp_fb);
      if (VECS[i].exp_fb)
        check(fba == VECS[i].exp_fba, "R8 R11", $sformatf("vec %0d flush address", i), fba, VECS[i].exp_fba);
      check(nws == int'(VECS[i].exp_ws), "R3 R4", $sformatf("vec %0d write-single requests", i), nws, VECS[i].exp_ws);
      check(snp == VECS[i].exp_snp, "R4 R7", $sformatf("vec %0d snooper address", i), snp, VECS[i].exp_snp);
      if (i == 10 || i == 13)  // R8: flush reply not awaited
        check(fb_tip, "R8", $sformatf("vec %0d flush still pending", i), fb_tip, 1);
    end

    // R5: no miss request went out under a flush it did not post itself
    check(r5_viol == 0, "R5", "requests under pending flush", r5_viol, 0);
    check(bad_cmd == 0, "R9", "request command codes", bad_cmd, 0);
    // R1: reset clears a pending non-flush flag
    access('{1'b0, 6'h20, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 6'h00, 6'h3F}, rd, nmap, nfb, nws, fba, snp, got);
    rst_n = 1'b0;
    @(negedge clk);
    check(!nonfb_tip && !fb_tip, "R1", "flags after mid-run reset", {nonfb_tip, fb_tip}, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule